// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside an 8-bit microcontroller core and decides which of seven peripheral request lines gets the CPU. The sources are two external pins, three timers, a serial port and a counter-array unit. Each source has its own enable bit, and a master enable gates all of them. Each source is also given one of four priority levels by two priority registers. The register that holds the more significant level bit is the one that adds levels 2 and 3. Software programs the three registers through a small write/read port.

On every cycle the controller picks the best pending request. A higher level always wins. Inside one level a fixed polling order decides. The winner is offered to the CPU only if its level is strictly above every level already in service. The request line and the vector address are registered. When the CPU acknowledges, the granted level is marked in service, and hardware clears the flag of the granted source if that source allows it. A return from the handler releases the most recent (highest) in-service level, so nested handlers unwind in the right order.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable and both priority registers are 0, `irq_o` is 0, `vector_o` is 00H, `insvc_o` is 0 and `flag_clr_o` is 0.
- R2: Register select 0 is the enable register, 1 is the level-low register and 2 is the level-high register. Select 3 reads as 00H. The enable register stores all 8 bits. The two priority registers store bits 6..0, and bit 7 of each reads 0. The source bit positions are: 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 counter-array.
- R3: While enable bit 7 (the master enable) is 0, `irq_o` stays 0 whatever the requests.
- R4: While the master enable is 1, a source can raise `irq_o` only when its own enable bit is 1.
- R5: A source's level is {level-high bit, level-low bit}, where 3 is the highest. The pending source with the highest level wins.
- R6: Among pending sources at the same level, the winner is the first in this order: external 0, timer 0, external 1, timer 1, counter-array, serial, timer 2.
- R7: The vector equals 8 × source index + 03H: external 0 03H, timer 0 0BH, external 1 13H, timer 1 1BH, serial 23H, timer 2 2BH, counter-array 33H.
- R8: An acknowledge while `irq_o` is 1 sets the `insvc_o` bit of the granted level, and `irq_o` reads 0 on the following cycle.
- R9: A request whose level is equal to or below the highest in-service level does not raise `irq_o`.
- R10: A request at a level strictly above every in-service level raises `irq_o` while the lower handler is still in service.
- R11: A return clears only the highest set bit of `insvc_o`. A request that this release unblocks raises `irq_o` on the second cycle after the return.
- R12: In the cycle after an acknowledge, `flag_clr_o` pulses for one cycle with the bit of the granted source, but only for timer 0, timer 1, and the external inputs whose `ext_edge_i` bit (bit 0 for external 0, bit 1 for external 1) is 1. For all other grants it stays 0.
- R13: `irq_o` and `vector_o` change one cycle after their inputs change. The acknowledge cycle holds `vector_o` unchanged, even if a new request arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req_i | input | 7 | Request flags, one per source (bit order as in R2) |
| ext_edge_i | input | 2 | 1 = external input is transition-triggered (bit 0 ext 0, bit 1 ext 1) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select (0 enable, 1 level-low, 2 level-high) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| ack_i | input | 1 | CPU takes the offered interrupt |
| reti_i | input | 1 | CPU returns from the current handler |
| irq_o | output | 1 | Registered interrupt request to the CPU |
| vector_o | output | 8 | Registered vector address of the offered source |
| insvc_o | output | 4 | In-service mask, one bit per level |
| flag_clr_o | output | 7 | One-cycle pulse that clears the granted source's flag |

## Verification
The hardest state to reach is a full nest with all four in-service bits set. It takes a specific sequence. Lower-level requests are held active, a source one level higher is added at each step, and each grant is acknowledged. Only then does every pending request become blocked. The bench builds this chain through levels 0 to 3. It then drops the top request before each return, so every intermediate mask can be checked while the unwind proceeds. The stack is fully popped with a level-0 request still held, and the bench confirms that this request is then offered again.

// File: rtl/irq_nest_pkg.sv
// Package: shared constants, types and helpers for the nested interrupt
// controller. Assumes seven sources and four levels (two priority bits).
package irq_nest_pkg;

    localparam int NSRC = 7;
    localparam int NLVL = 4;
    localparam int DW   = 8;
    localparam int IDXW = $clog2(NSRC);

    typedef logic [IDXW-1:0] idx_t;

    // Source bit positions (shared by enable and priority registers)
    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;
    localparam int SRC_TMR2 = 5;
    localparam int SRC_CNTA = 6;

    // Register select codes
    typedef enum logic [1:0] {
        SEL_ENA  = 2'd0,
        SEL_PLO  = 2'd1,
        SEL_PHI  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // Polling order inside one level, first entry wins
    localparam idx_t POLL_ORDER [0:NSRC-1] = '{
        idx_t'(SRC_EXT0), idx_t'(SRC_TMR0), idx_t'(SRC_EXT1), idx_t'(SRC_TMR1),
        idx_t'(SRC_CNTA), idx_t'(SRC_SER),  idx_t'(SRC_TMR2)
    };

    // Vector address: eight bytes per source, offset 3
    function automatic logic [DW-1:0] vec_of(input idx_t idx);
        return DW'({idx, 3'b011});
    endfunction

endpackage

// File: rtl/irq_nest_regs.sv
// Module: software-visible enable and priority registers with read mux.
// Assumes the enable register is one bit wider than the source count,
// its top bit acting as master enable.
module irq_nest_regs
    import irq_nest_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              glob_en,
    output logic [N_SRC-1:0]  src_en,
    output logic [N_SRC-1:0]  lvl_lo,
    output logic [N_SRC-1:0]  lvl_hi
);

    localparam int GLOB_BIT = DATA_W - 1;

    logic [DATA_W-1:0] ena_q;
    logic [N_SRC-1:0]  plo_q;
    logic [N_SRC-1:0]  phi_q;

    // Register writes, decoded by select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= '0;
            plo_q <= '0;
            phi_q <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(sel))
                SEL_ENA: ena_q <= wdata;
                SEL_PLO: plo_q <= wdata[N_SRC-1:0];
                SEL_PHI: phi_q <= wdata[N_SRC-1:0];
                default: ;
            endcase
        end
    end

    // Read-back mux; unused bits return zero
    always_comb begin
        case (reg_sel_e'(sel))
            SEL_ENA: rdata = ena_q;
            SEL_PLO: rdata = DATA_W'(plo_q);
            SEL_PHI: rdata = DATA_W'(phi_q);
            default: rdata = '0;
        endcase
    end

    assign glob_en = ena_q[GLOB_BIT];
    assign src_en  = ena_q[N_SRC-1:0];
    assign lvl_lo  = plo_q;
    assign lvl_hi  = phi_q;

endmodule

// File: rtl/irq_nest_arb.sv
// Module: combinational winner selection. Groups pending sources by level,
// applies the fixed polling order in each level, and keeps the highest
// level that the in-service state still allows.
module irq_nest_arb
    import irq_nest_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int N_LVL = NLVL
) (
    input  logic [N_SRC-1:0]         pend,
    input  logic [N_SRC-1:0]         lvl_lo,
    input  logic [N_SRC-1:0]         lvl_hi,
    input  logic [N_LVL-1:0]         lvl_ok,
    output logic                     win_vld,
    output idx_t                     win_idx,
    output logic [$clog2(N_LVL)-1:0] win_lvl
);

    localparam int LVLW = $clog2(N_LVL);

    logic [N_LVL-1:0]            lvl_any;
    logic [N_LVL-1:0][IDXW-1:0]  pick_w;

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        logic [N_SRC-1:0] hit;
        idx_t             pick;

        // Sources pending at this level
        always_comb begin
            for (int s = 0; s < N_SRC; s++)
                hit[s] = pend[s] && ({lvl_hi[s], lvl_lo[s]} == LVLW'(g));
        end

        // First hit in polling order
        always_comb begin
            pick = '0;
            for (int k = N_SRC - 1; k >= 0; k--)
                if (hit[POLL_ORDER[k]]) pick = POLL_ORDER[k];
        end

        assign lvl_any[g] = (|hit) && lvl_ok[g];
        assign pick_w[g]  = pick;
    end

    // Highest allowed level with a hit wins
    always_comb begin
        win_vld = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (lvl_any[l]) begin
                win_vld = 1'b1;
                win_idx = pick_w[l];
                win_lvl = LVLW'(l);
            end
        end
    end

endmodule

// File: rtl/irq_nest_isr.sv
// Module: in-service mask, one bit per level. Acknowledge sets the granted
// level; return clears the highest set bit. Also derives which levels may
// still be offered (strictly above every in-service level).
module irq_nest_isr #(
    parameter int N_LVL = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     set_en,
    input  logic [$clog2(N_LVL)-1:0] set_lvl,
    input  logic                     pop_en,
    output logic [N_LVL-1:0]         insvc,
    output logic [N_LVL-1:0]         lvl_ok
);

    logic [N_LVL-1:0] insvc_q;
    logic [N_LVL-1:0] insvc_d;
    logic [N_LVL-1:0] top_oh;

    // One-hot of the highest in-service level
    always_comb begin
        top_oh = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (insvc_q[l]) begin
                top_oh    = '0;
                top_oh[l] = 1'b1;
            end
        end
    end

    // Next mask: release first, then mark the newly granted level
    always_comb begin
        insvc_d = insvc_q & ~(pop_en ? top_oh : '0);
        if (set_en) insvc_d[set_lvl] = 1'b1;
    end

    // Mask register
    always_ff @(posedge clk) begin
        if (!rst_n) insvc_q <= '0;
        else        insvc_q <= insvc_d;
    end

    for (genvar g = 0; g < N_LVL; g++) begin : g_ok
        assign lvl_ok[g] = ~|insvc_q[N_LVL-1:g];
    end

    assign insvc = insvc_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
// Module: top of the four-level nested interrupt controller. Gates the
// requests with the enables, arbitrates, registers request and vector, and
// drives the in-service mask and the hardware flag-clear pulse.
// Assumes the CPU acknowledges only while irq_o is high; an acknowledge
// with irq_o low is ignored.
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int N_SRC  = NSRC,
    parameter int N_LVL  = NLVL,
    parameter int DATA_W = DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_req_i,
    input  logic [1:0]        ext_edge_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              ack_i,
    input  logic              reti_i,
    output logic              irq_o,
    output logic [DATA_W-1:0] vector_o,
    output logic [N_LVL-1:0]  insvc_o,
    output logic [N_SRC-1:0]  flag_clr_o
);

    localparam int LVLW = $clog2(N_LVL);

    logic             glob_en;
    logic [N_SRC-1:0] src_en, lvl_lo, lvl_hi, pend;
    logic [N_LVL-1:0] lvl_ok;
    logic             win_vld;
    idx_t             win_idx;
    logic [LVLW-1:0]  win_lvl;

    logic              irq_q;
    logic [DATA_W-1:0] vec_q;
    idx_t              idx_q;
    logic [LVLW-1:0]   lvl_q;
    logic [N_SRC-1:0]  clr_q;
    logic [N_SRC-1:0]  clr_mask, grant_oh;
    logic              take;

    irq_nest_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_i),
        .sel     (reg_sel_i),
        .wdata   (reg_wdata_i),
        .rdata   (reg_rdata_o),
        .glob_en (glob_en),
        .src_en  (src_en),
        .lvl_lo  (lvl_lo),
        .lvl_hi  (lvl_hi)
    );

    assign pend = src_req_i & src_en & {N_SRC{glob_en}};
    assign take = ack_i && irq_q;

    irq_nest_arb #(.N_SRC(N_SRC), .N_LVL(N_LVL)) u_arb (
        .pend    (pend),
        .lvl_lo  (lvl_lo),
        .lvl_hi  (lvl_hi),
        .lvl_ok  (lvl_ok),
        .win_vld (win_vld),
        .win_idx (win_idx),
        .win_lvl (win_lvl)
    );

    irq_nest_isr #(.N_LVL(N_LVL)) u_isr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (take),
        .set_lvl (lvl_q),
        .pop_en  (reti_i),
        .insvc   (insvc_o),
        .lvl_ok  (lvl_ok)
    );

    // Sources whose flag hardware clears on grant
    always_comb begin
        clr_mask           = '0;
        clr_mask[SRC_TMR0] = 1'b1;
        clr_mask[SRC_TMR1] = 1'b1;
        clr_mask[SRC_EXT0] = ext_edge_i[0];
        clr_mask[SRC_EXT1] = ext_edge_i[1];
        grant_oh           = '0;
        grant_oh[idx_q]    = 1'b1;
    end

    // Offer register: frozen across an acknowledge, else follows the arbiter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= '0;
            idx_q <= '0;
            lvl_q <= '0;
            clr_q <= '0;
        end else if (take) begin
            irq_q <= 1'b0;
            clr_q <= grant_oh & clr_mask;
        end else begin
            irq_q <= win_vld;
            clr_q <= '0;
            if (win_vld) begin
                vec_q <= vec_of(win_idx);
                idx_q <= win_idx;
                lvl_q <= win_lvl;
            end
        end
    end

    assign irq_o      = irq_q;
    assign vector_o   = vec_q;
    assign flag_clr_o = clr_q;

endmodule

// File: rtl/irq_nest_chk.sv
// Module: property checker attached to the controller top by bind.
module irq_nest_chk #(
    parameter int N_SRC  = 7,
    parameter int N_LVL  = 4,
    parameter int DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ack_i,
    input logic                     reti_i,
    input logic                     irq_o,
    input logic [DATA_W-1:0]        vector_o,
    input logic [N_LVL-1:0]         insvc_o,
    input logic [N_SRC-1:0]         flag_clr_o,
    input logic                     glob_en,
    input logic [$clog2(N_LVL)-1:0] irq_lvl
);

    // R3
    glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !irq_o);

    // R8
    ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> (!irq_o && insvc_o[$past(irq_lvl)]));

    // R9
    blocked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((insvc_o >> irq_lvl) == '0));

    // R11
    reti_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !(ack_i && irq_o) && (insvc_o != '0))
        |=> ($countones(insvc_o) + 1 == $countones($past(insvc_o))));

    // R12
    clr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_o != '0) |-> $past(ack_i && irq_o));

    // R12
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr_o));

    // R13
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_o) |=> $stable(vector_o));

endmodule

bind irq_nest_ctrl irq_nest_chk #(
    .N_SRC(N_SRC), .N_LVL(N_LVL), .DATA_W(DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ack_i      (ack_i),
    .reti_i     (reti_i),
    .irq_o      (irq_o),
    .vector_o   (vector_o),
    .insvc_o    (insvc_o),
    .flag_clr_o (flag_clr_o),
    .glob_en    (glob_en),
    .irq_lvl    (lvl_q)
);

// File: tb/irq_nest_ctrl_test.sv
// Scoreboard bench: driver tasks push expected items, a monitor compares.
module irq_nest_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] src_req_i = '0;
    logic [1:0] ext_edge_i = 2'b11;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_sel_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       ack_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       irq_o;
    logic [7:0] vector_o;
    logic [3:0] insvc_o;
    logic [6:0] flag_clr_o;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req_i(src_req_i), .ext_edge_i(ext_edge_i),
        .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .ack_i(ack_i), .reti_i(reti_i), .irq_o(irq_o),
        .vector_o(vector_o), .insvc_o(insvc_o), .flag_clr_o(flag_clr_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       tag;
        int          kind;
        logic [31:0] exp;
    } sb_item_t;

    sb_item_t   sb_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] hold_vec = 8'h00;
    bit         done = 1'b0;

    // Monitor: compares queued expectations shortly after each falling edge
    initial forever begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            sb_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            if (it.kind == 0) act = {12'd0, flag_clr_o, irq_o, vector_o, insvc_o};
            else              act = {24'd0, reg_rdata_o};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expect {flag_clr, irq, vector, insvc}; vector holds while irq is low
    task automatic chk(input string tag, input logic e_irq, input logic [7:0] e_vec,
                       input logic [3:0] e_isv, input logic [6:0] e_clr);
        sb_item_t it;
        if (e_irq) hold_vec = e_vec;
        it.tag  = tag;
        it.kind = 0;
        it.exp  = {12'd0, e_clr, e_irq, hold_vec, e_isv};
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic rdchk(input string tag, input logic [1:0] sel, input logic [7:0] e);
        sb_item_t it;
        reg_sel_i = sel;
        it.tag  = tag;
        it.kind = 1;
        it.exp  = {24'd0, e};
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_wr_i = 1'b1;
        reg_sel_i = sel;
        reg_wdata_i = d;
        tick(1);
        reg_wr_i = 1'b0;
        tick(1);
    endtask

    task automatic set_src(input logic [6:0] v);
        src_req_i = v;
        tick(2);
    endtask

    task automatic do_ack(input logic [6:0] new_src);
        ack_i = 1'b1;
        src_req_i = new_src;
        tick(1);
        ack_i = 1'b0;
    endtask

    task automatic do_reti();
        reti_i = 1'b1;
        tick(1);
        reti_i = 1'b0;
        tick(1);
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Driver
    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset outputs", 1'b0, 8'h00, 4'h0, 7'h00);
        rdchk("R1 reset enable", 2'd0, 8'h00);
        rdchk("R1 reset level-high", 2'd2, 8'h00);

        wr(2'd0, 8'hC3);
        rdchk("R2 enable readback", 2'd0, 8'hC3);
        wr(2'd1, 8'hAA);
        rdchk("R2 level-low bit7 zero", 2'd1, 8'h2A);
        wr(2'd2, 8'hD5);
        rdchk("R2 level-high bit7 zero", 2'd2, 8'h55);
        rdchk("R2 unused select", 2'd3, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h00);

        set_src(7'h7F);
        wr(2'd0, 8'h7F);
        chk("R3 master enable off", 1'b0, 8'h00, 4'h0, 7'h00);
        wr(2'd0, 8'h80);
        chk("R4 no source enabled", 1'b0, 8'h00, 4'h0, 7'h00);
        wr(2'd0, 8'hA0);
        chk("R4 only timer 2 enabled", 1'b1, 8'h2B, 4'h0, 7'h00);

        wr(2'd0, 8'hFF);
        chk("R6 R7 ext0 first", 1'b1, 8'h03, 4'h0, 7'h00);
        set_src(7'h7E);
        chk("R6 R7 timer0", 1'b1, 8'h0B, 4'h0, 7'h00);
        set_src(7'h7C);
        chk("R6 R7 ext1", 1'b1, 8'h13, 4'h0, 7'h00);
        set_src(7'h78);
        chk("R6 R7 timer1", 1'b1, 8'h1B, 4'h0, 7'h00);
        set_src(7'h70);
        chk("R6 R7 counter-array before serial", 1'b1, 8'h33, 4'h0, 7'h00);
        set_src(7'h30);
        chk("R6 R7 serial", 1'b1, 8'h23, 4'h0, 7'h00);
        set_src(7'h20);
        chk("R6 R7 timer2", 1'b1, 8'h2B, 4'h0, 7'h00);

        set_src(7'h7F);
        wr(2'd2, 8'h10);
        chk("R5 serial level 2 wins", 1'b1, 8'h23, 4'h0, 7'h00);
        wr(2'd1, 8'h24);
        chk("R5 level 1 loses to level 2", 1'b1, 8'h23, 4'h0, 7'h00);
        wr(2'd2, 8'h14);
        chk("R5 ext1 level 3 wins", 1'b1, 8'h13, 4'h0, 7'h00);

        // Levels now: ext0 0, timer0 0, ext1 3, timer1 0, serial 2, timer2 1, cnt 0
        set_src(7'h01);
        chk("R10 ext0 idle offer", 1'b1, 8'h03, 4'h0, 7'h00);
        do_ack(7'h01);
        chk("R8 R12 ext0 edge grant", 1'b0, 8'h03, 4'b0001, 7'b0000001);
        tick(1);
        chk("R9 R12 same level blocked, pulse gone", 1'b0, 8'h03, 4'b0001, 7'h00);
        set_src(7'h03);
        chk("R9 timer0 equal level blocked", 1'b0, 8'h03, 4'b0001, 7'h00);
        set_src(7'h23);
        chk("R10 timer2 preempts level 0", 1'b1, 8'h2B, 4'b0001, 7'h00);
        do_ack(7'h23);
        chk("R8 R12 timer2 grant no clear", 1'b0, 8'h2B, 4'b0011, 7'h00);
        tick(1);
        set_src(7'h33);
        chk("R10 serial preempts level 1", 1'b1, 8'h23, 4'b0011, 7'h00);
        do_ack(7'h33);
        chk("R8 serial grant", 1'b0, 8'h23, 4'b0111, 7'h00);
        tick(1);
        set_src(7'h37);
        chk("R10 ext1 preempts level 2", 1'b1, 8'h13, 4'b0111, 7'h00);
        do_ack(7'h37);
        chk("R8 R12 ext1 edge grant", 1'b0, 8'h13, 4'b1111, 7'b0000100);
        tick(1);
        chk("R9 full nest blocks all", 1'b0, 8'h13, 4'b1111, 7'h00);

        set_src(7'h33);
        do_reti();
        chk("R11 pop level 3", 1'b0, 8'h13, 4'b0111, 7'h00);
        set_src(7'h23);
        do_reti();
        chk("R11 pop level 2", 1'b0, 8'h13, 4'b0011, 7'h00);
        set_src(7'h03);
        do_reti();
        chk("R11 pop level 1", 1'b0, 8'h13, 4'b0001, 7'h00);
        do_reti();
        chk("R11 unblocked ext0 offered", 1'b1, 8'h03, 4'b0000, 7'h00);

        ext_edge_i = 2'b00;
        do_ack(7'h01);
        chk("R12 ext0 level mode no clear", 1'b0, 8'h03, 4'b0001, 7'h00);
        do_reti();
        chk("R11 ext0 offered again", 1'b1, 8'h03, 4'b0000, 7'h00);
        set_src(7'h02);
        chk("R13 follows request change", 1'b1, 8'h0B, 4'b0000, 7'h00);
        do_ack(7'h06);
        chk("R13 R12 vector held, timer0 cleared", 1'b0, 8'h0B, 4'b0001, 7'b0000010);
        tick(1);
        chk("R13 R10 late ext1 offered", 1'b1, 8'h13, 4'b0001, 7'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule